// File: doc/BRIEF.md
# Pixel-Locked Switching Regulator Sync Generator

This block drives the sync inputs of switching regulators so that their switching edges stay locked to the detector's pixel timing. The acquisition sequencer raises a one-cycle strobe once per pixel. The block counts reference clock cycles between successive strobes to measure the pixel period. It then divides that period by the smallest power of two, from 1 to 128, that brings the result at or below a programmable maximum divider. Only shifts are used, so there is no general divider in the block.

Software sets the limits as raw divider counts in reference cycles. A result below the minimum limit, a zero result, a period that no allowed shift can bring under the maximum, or a strobe that does not arrive in time all stop the outputs and raise an out-of-range flag. The selected divider is available as a read-only monitoring value.

All four sync outputs come from one shared phase counter, which reloads at every measured strobe. The pulses therefore stay a fixed number of cycles behind the strobe. The outputs are either coincident or spread in equal fractions of the sync period.

Top module: `pixsync_gen`

## Requirements
- R1: After reset, `sync_out` is 0, `div_value` is 0 and `out_of_range` is 0.
- R2: The first strobe after reset, or after a timeout, only starts a measurement. It leaves `div_value` and the outputs unchanged. Each later strobe measures the period as the number of clock edges since the previous strobe.
- R3: The divider is period >> k, where k is the smallest value in 0..7 with (period >> k) <= `div_max`. If no k qualifies, the value shown is period >> 7. `div_value` shows the divider from the second clock edge after the strobe cycle.
- R4: If no k qualifies, or the divider is below `div_min`, or the divider is 0, then `out_of_range` is 1 and `sync_out` stays 0.
- R5: If `TIMEOUT_CYC` clock edges pass after a strobe with no further strobe, `out_of_range` becomes 1, `sync_out` goes to 0, and the next strobe only starts a new measurement.
- R6: While running with divider D, each output is high for floor(D/2) cycles of every D cycles. The phase counter runs 0..D-1, and the undelayed output is high for phases below floor(D/2).
- R7: Every measured strobe reloads the phase to 0. In the cycle two clock cycles after the strobe cycle, an output with zero offset is high whenever D >= 2.
- R8: `div_value` and the sync period change only at a measured strobe. A change of `div_max` or `div_min` between strobes has no effect until the next strobe.
- R9: With `phase_mode` = 0, all four outputs are identical in every cycle.
- R10: With `phase_mode` = 1, output i lags output 0 by floor(i*D/4) cycles, taken modulo D. `phase_mode` acts at once and needs no strobe.
- R11: A measured strobe whose divider is in range clears `out_of_range` and starts the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_strobe | input | 1 | One-cycle pixel strobe from the sequencer |
| div_min | input | CNT_W | Smallest divider accepted, in clock cycles |
| div_max | input | CNT_W | Largest divider accepted, in clock cycles |
| phase_mode | input | 1 | 0 = coincident outputs, 1 = outputs spread in quarters |
| sync_out | output | NUM_OUT | Regulator sync pulses |
| div_value | output | CNT_W | Divider chosen at the last measured strobe |
| out_of_range | output | 1 | Outputs stopped by a limit violation or a timeout |

## Verification
A measured strobe sets the divider, the running flag and phase 0 at the second rising edge after the strobe cycle. The new divider and the restarted pulse are therefore due in the cycle after that edge, and the bench checks them at the falling edge that follows. The per-edge reference model advances one step per rising edge with the same inputs, and its outputs are compared at every falling edge. This keeps both the two-edge latency and the combinational effect of `phase_mode` aligned, because the bench changes `phase_mode` and the limits only a short time after a falling edge. A timeout is checked a few cycles after `TIMEOUT_CYC` edges have passed. The effect of a limit change is checked both before and after the next strobe.

// File: rtl/pixsync_pkg.sv
package pixsync_pkg;
  localparam int MAX_SHIFT = 7;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  typedef enum logic {
    PH_ALIGNED = 1'b0,
    PH_SPREAD  = 1'b1
  } phase_mode_e;

  typedef struct packed {
    logic               fits;
    logic [SHIFT_W-1:0] shift;
  } shift_pick_t;
endpackage

// File: rtl/pixsync_period_meter.sv
module pixsync_period_meter #(
  parameter int CNT_W       = 16,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic [CNT_W-1:0] period_q,
  output logic             meas_vld_q,
  output logic             timeout_evt
);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             have_ref_q;

  assign timeout_evt = have_ref_q && !strobe && (cnt_q == TO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
      period_q   <= '0;
      meas_vld_q <= 1'b0;
    end else begin
      meas_vld_q <= strobe && have_ref_q;
      if (strobe) begin
        if (have_ref_q) period_q <= cnt_q + CNT_W'(1);
        cnt_q      <= '0;
        have_ref_q <= 1'b1;
      end else if (timeout_evt) begin
        cnt_q      <= '0;
        have_ref_q <= 1'b0;
      end else if (have_ref_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assert_no_meas_without_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !have_ref_q) |=> !meas_vld_q);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TO_LAST);
  assert_timeout_drops_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !have_ref_q);
endmodule

// File: rtl/pixsync_div_select.sv
module pixsync_div_select
  import pixsync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] div_min,
  input  logic [CNT_W-1:0] div_max,
  input  logic             timeout_evt,
  output logic [CNT_W-1:0] div_q,
  output logic             run_q,
  output logic             oor_q
);
  // Smallest shift that brings the period under the limit; the descending
  // loop leaves the smallest qualifying shift as its last assignment.
  function automatic shift_pick_t pick_shift(input logic [CNT_W-1:0] per,
                                             input logic [CNT_W-1:0] lim);
    shift_pick_t r;
    r.fits  = 1'b0;
    r.shift = SHIFT_W'(MAX_SHIFT);
    for (int k = MAX_SHIFT; k >= 0; k--) begin
      if ((per >> k) <= lim) begin
        r.fits  = 1'b1;
        r.shift = SHIFT_W'(k);
      end
    end
    return r;
  endfunction

  shift_pick_t      pick;
  logic [CNT_W-1:0] cand;
  logic             cand_ok;

  always_comb begin
    pick    = pick_shift(period, div_max);
    cand    = period >> pick.shift;
    cand_ok = pick.fits && (cand >= div_min) && (cand != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      run_q <= 1'b0;
      oor_q <= 1'b0;
    end else if (meas_vld) begin
      div_q <= cand;
      run_q <= cand_ok;
      oor_q <= !cand_ok;
    end else if (timeout_evt) begin
      run_q <= 1'b0;
      oor_q <= 1'b1;
    end
  end

  assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> $stable(div_q));
  assert_stop_when_oor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oor_q |-> !run_q);
  assert_div_under_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> (!run_q || (div_q <= $past(div_max))));
  assert_div_over_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |=> (!run_q || (div_q >= $past(div_min))));
endmodule

// File: rtl/pixsync_phase_gen.sv
module pixsync_phase_gen
  import pixsync_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               run,
  input  logic [CNT_W-1:0]   div,
  input  phase_mode_e        mode,
  output logic [NUM_OUT-1:0] sync
);
  localparam int OUT_LG = $clog2(NUM_OUT);
  localparam int PW     = CNT_W + OUT_LG;

  logic [CNT_W-1:0] phase_q;

  // High while the delayed phase sits in the first half of the period.
  function automatic logic tap_high(input logic [CNT_W-1:0] ph,
                                    input logic [CNT_W-1:0] dv,
                                    input logic [CNT_W-1:0] off);
    logic [CNT_W:0] rel;
    if (ph >= off) rel = {1'b0, ph - off};
    else           rel = {1'b0, ph} + {1'b0, dv} - {1'b0, off};
    return rel < {2'b00, dv[CNT_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (load) begin
      phase_q <= '0;
    end else if (run) begin
      if (phase_q >= div - CNT_W'(1)) phase_q <= '0;
      else                            phase_q <= phase_q + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_tap
    logic [PW-1:0]    prod;
    logic [CNT_W-1:0] off_g;
    assign prod   = PW'(div) * PW'(g);
    assign off_g  = (mode == PH_SPREAD) ? prod[PW-1:OUT_LG] : '0;
    assign sync[g] = run && tap_high(phase_q, div, off_g);
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase_q == '0));
  assert_phase_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase_q < div));
  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PH_ALIGNED) |-> ((sync == '0) || (&sync)));
endmodule

// File: rtl/pixsync_gen.sv
module pixsync_gen
  import pixsync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_OUT     = 4,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_strobe,
  input  logic [CNT_W-1:0]   div_min,
  input  logic [CNT_W-1:0]   div_max,
  input  logic               phase_mode,
  output logic [NUM_OUT-1:0] sync_out,
  output logic [CNT_W-1:0]   div_value,
  output logic               out_of_range
);
  logic [CNT_W-1:0] period;
  logic             meas_vld;
  logic             timeout_evt;
  logic [CNT_W-1:0] div_q;
  logic             run_q;
  logic             oor_q;
  phase_mode_e      mode;

  assign mode = phase_mode_e'(phase_mode);

  pixsync_period_meter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .strobe(pix_strobe),
    .period_q(period), .meas_vld_q(meas_vld), .timeout_evt(timeout_evt));

  pixsync_div_select #(.CNT_W(CNT_W)) u_select (
    .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .period(period),
    .div_min(div_min), .div_max(div_max), .timeout_evt(timeout_evt),
    .div_q(div_q), .run_q(run_q), .oor_q(oor_q));

  pixsync_phase_gen #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(meas_vld), .run(run_q),
    .div(div_q), .mode(mode), .sync(sync_out));

  assign div_value    = div_q;
  assign out_of_range = oor_q;

  assert_quiet_when_oor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (sync_out == '0));
  assert_timeout_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (out_of_range && (sync_out == '0)));
endmodule

// File: tb/pixsync_gen_test.sv
`timescale 1ns/1ps
module pixsync_gen_test;
  localparam int CW = 16;
  localparam int NO = 4;
  localparam int TO = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_strobe = 1'b0;
  logic [CW-1:0] div_min = 16'd4;
  logic [CW-1:0] div_max = 16'd40;
  logic          phase_mode = 1'b0;
  logic [NO-1:0] sync_out;
  logic [CW-1:0] div_value;
  logic          out_of_range;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  pixsync_gen #(.CNT_W(CW), .NUM_OUT(NO), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .pix_strobe(pix_strobe), .div_min(div_min),
    .div_max(div_max), .phase_mode(phase_mode), .sync_out(sync_out),
    .div_value(div_value), .out_of_range(out_of_range));

  // Behavioural reference, one step per rising edge.
  int m_ref, m_cnt, m_pend, m_per, m_div, m_run, m_oor, m_phase;

  always @(posedge clk) begin
    int k, d, ok, tmo, newpend;
    if (!rst_n) begin
      m_ref = 0; m_cnt = 0; m_pend = 0; m_per = 0;
      m_div = 0; m_run = 0; m_oor = 0; m_phase = 0;
    end else begin
      newpend = (pix_strobe && m_ref) ? 1 : 0;
      tmo = (m_ref && !pix_strobe && m_cnt == TO - 1) ? 1 : 0;
      if (m_pend) begin
        k = 0;
        while (k <= 7 && (m_per >> k) > int'(div_max)) k++;
        if (k > 7) begin d = m_per >> 7; ok = 0; end
        else begin d = m_per >> k; ok = (d >= int'(div_min) && d != 0) ? 1 : 0; end
        m_div = d; m_run = ok; m_oor = ok ? 0 : 1; m_phase = 0;
      end else begin
        if (m_run) m_phase = (m_phase + 1 >= m_div) ? 0 : m_phase + 1;
        if (tmo) begin m_run = 0; m_oor = 1; end
      end
      if (pix_strobe) begin
        if (m_ref) m_per = m_cnt + 1;
        m_cnt = 0; m_ref = 1;
      end else if (tmo) begin
        m_ref = 0; m_cnt = 0;
      end else if (m_ref) m_cnt++;
      m_pend = newpend;
    end
  end

  function automatic int exp_sync();
    int r = 0;
    for (int i = 0; i < NO; i++) begin
      int off, rel;
      off = phase_mode ? (m_div * i) / NO : 0;
      if (m_run && m_div > 0) begin
        rel = ((m_phase - off) % m_div + m_div) % m_div;
        if (rel < m_div / 2) r |= (1 << i);
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 sync vs model", int'(sync_out), exp_sync());
      chk("R3 div_value vs model", int'(div_value), m_div);
      chk("R4 out_of_range vs model", int'(out_of_range), m_oor);
    end
  end

  task automatic send(input int gap);
    pix_strobe = 1'b1;
    @(negedge clk);
    pix_strobe = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  // Strobe, then stop at the falling edge where the restart is visible.
  task automatic strobe2();
    pix_strobe = 1'b1;
    @(negedge clk);
    pix_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int hi, pat;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sync", int'(sync_out), 0);
    chk("R1 reset div", int'(div_value), 0);
    chk("R1 reset oor", int'(out_of_range), 0);

    send(100);
    chk("R2 first strobe no div", int'(div_value), 0);
    chk("R2 first strobe no sync", int'(sync_out), 0);

    strobe2();
    chk("R7 restart high", int'(sync_out), 15);
    chk("R3 div 100>>2", int'(div_value), 25);
    chk("R11 in range", int'(out_of_range), 0);
    hi = 0;
    for (int c = 0; c < 25; c++) begin
      if (sync_out[0]) hi++;
      chk("R9 outputs equal", int'(sync_out == '0 || &sync_out), 1);
      @(negedge clk);
    end
    chk("R6 high cycles", hi, 12);
    repeat (100 - 2 - 25) @(negedge clk);

    strobe2();
    #1 div_max = 16'd10;
    repeat (10) @(negedge clk);
    chk("R8 div held mid period", int'(div_value), 25);
    repeat (100 - 12) @(negedge clk);
    strobe2();
    chk("R8 div at strobe", int'(div_value), 6);
    repeat (37 - 2) @(negedge clk);

    #1 div_max = 16'd40;
    strobe2();
    repeat (37 - 2) @(negedge clk);
    strobe2();
    chk("R3 shift zero", int'(div_value), 37);
    #1 div_max = 16'd36;
    repeat (37 - 2) @(negedge clk);
    strobe2();
    chk("R3 shift one", int'(div_value), 18);
    repeat (300 - 2) @(negedge clk);

    #1 div_max = 16'd2;
    strobe2();
    chk("R4 below min oor", int'(out_of_range), 1);
    chk("R4 below min div", int'(div_value), 2);
    repeat (5) @(negedge clk);
    chk("R4 below min quiet", int'(sync_out), 0);
    #1 div_max = 16'd1;
    repeat (300 - 7) @(negedge clk);
    strobe2();
    chk("R4 no shift fits oor", int'(out_of_range), 1);
    chk("R4 no shift fits div", int'(div_value), 2);
    repeat (100 - 2) @(negedge clk);

    #1 begin div_max = 16'd40; phase_mode = 1'b1; end
    strobe2();
    chk("R11 recovers", int'(out_of_range), 0);
    pat = 0;
    for (int i = 0; i < NO; i++)
      if (((25 - (25 * i) / NO) % 25) < 12) pat |= (1 << i);
    chk("R10 spread at phase 0", int'(sync_out), pat);
    repeat (100 - 2) @(negedge clk);
    strobe2();
    repeat (6) @(negedge clk);
    chk("R10 output 1 lags 6", int'(sync_out[1]), 1);

    repeat (TO + 5) @(negedge clk);
    chk("R5 timeout oor", int'(out_of_range), 1);
    chk("R5 timeout quiet", int'(sync_out), 0);
    send(100);
    chk("R5 restart measures only", int'(out_of_range), 1);
    strobe2();
    chk("R11 after timeout", int'(out_of_range), 0);
    chk("R5 div after timeout", int'(div_value), 25);
    repeat (20) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule